// File: doc/BRIEF.md
# Bus-Programmed Channel Enable Register

This block is a serial-bus target (I2C protocol, up to 400 kHz SCL) that owns one 8-bit selection register. Its 8-bit enable vector gates downstream bus segments, one bit per segment. A fast system clock oversamples SCL and SDA. The block pulls SDA low through an open-drain enable output and never drives SCL.

A controller addresses the block with the fixed prefix `1110` followed by three board-strap inputs. On a write it sends one or more selection bytes. On a read it gets the stored selection back. A written selection is held in the register and reaches the enable vector only when the bus sees a STOP. This means no segment is joined while a transfer is still in progress. An active-low synchronous reset frees a stuck bus by clearing the register, clearing the outputs and returning the protocol engine to idle.

Top module: `i2csel_switch`

## Requirements
- R1: The block answers only to the 7-bit address formed by `1110` followed by `addr_strap[2]`, `addr_strap[1]`, `addr_strap[0]`, sent MSB first. The eighth bit selects read (1) or write (0).
- R2: On a write, each data byte is stored in the selection register as it arrives, so after a transfer of several bytes the register holds the last byte.
- R3: A read transfer returns the current selection register contents.
- R4: Bit n of the selection register drives `chan_en[n]`, and any combination of bits, including several at once, may be set.
- R5: A new selection appears on `chan_en` only in the cycle after a STOP is detected. Before that, `chan_en` keeps its previous value.
- R6: While `rst_n` is low at a clock edge, the register and `chan_en` clear to 0x00 and the protocol engine returns to idle. This is also the state after the first reset.
- R7: The block acknowledges a matching address and every write data byte by pulling SDA low for the ninth clock. On an address mismatch it leaves SDA released and ignores the bus until the next START or STOP.
- R8: Read data is sent MSB first, and the block changes its SDA drive only while SCL is low.
- R9: If the controller acknowledges a read byte, the block sends the register value again. If the controller does not acknowledge, the block releases SDA.
- R10: A repeated START abandons the current byte and restarts address reception, and it does not apply a written selection to `chan_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strap | input | 3 | Board-strapped low address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| chan_en | output | 8 | Per-segment enable vector |

## Verification
Selections are written both as single bytes and as bursts of one to three random bytes. The enable vector is checked before the STOP and again after it, which separates the timing of register storage from the timing of output application and shows which byte of a burst is kept. Random strap values, together with a deliberately wrong address, show whether the address comparison uses all three strap bits and whether a non-matching transfer can touch the register. Reads that end with an acknowledge and then a not-acknowledge, a repeated START placed between a write and a read, and a reset issued with a selection still pending cover the remaining control paths.

// File: rtl/i2csel_pkg.sv
package i2csel_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2csel_sync.sv
module i2csel_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2csel_cond.sv
module i2csel_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // data edges while the clock line stays high are bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
endmodule

// File: rtl/i2csel_fsm.sv
module i2csel_fsm
  import i2csel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1110,
  parameter int         STRAP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [BYTE_W-1:0] rd_val,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  tgt_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              byte_done;
  logic              rw_q;
  logic              mack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      byte_done <= 1'b0;
      rw_q      <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_byte   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              if (bitcnt == CNT_W'(BYTE_W-1)) byte_done <= 1'b1;
              else bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              bitcnt    <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_AACK;
                end else begin
                  state  <= ST_SKIP;
                end
              end else begin
                wr_stb  <= 1'b1;
                wr_byte <= shreg;
                sda_oe  <= 1'b1;
                state   <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                txreg  <= rd_val;
                sda_oe <= ~rd_val[BYTE_W-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bitcnt == CNT_W'(BYTE_W-1)) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RACK;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                sda_oe <= ~txreg[BYTE_W-2];
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txreg  <= rd_val;
                sda_oe <= ~rd_val[BYTE_W-1];
                state  <= ST_RDAT;
              end else begin
                state  <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2csel_switch.sv
module i2csel_switch
  import i2csel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1110,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [BYTE_W-1:0]  chan_en
);
  logic              scl_s, sda_s;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] ctrl_q;

  i2csel_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  i2csel_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2csel_fsm #(.ADDR_HI(ADDR_HI), .STRAP_W(STRAP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (addr_strap),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .rd_val    (ctrl_q),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte)
  );

  // stored selection: updated per received byte
  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_stb) ctrl_q <= wr_byte;
  end

  // applied selection: follows the register only at a STOP
  always_ff @(posedge clk) begin
    if (!rst_n)        chan_en <= '0;
    else if (stop_det) chan_en <= ctrl_q;
  end
endmodule

// File: rtl/i2csel_checker.sv
module i2csel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] chan_en,
  input logic [7:0] ctrl_q,
  input logic       stop_det,
  input logic       scl_s,
  input logic       sda_oe
);
  // R5
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> ($past(stop_det) || !$past(rst_n)));

  // R5
  chan_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> (chan_en == $past(ctrl_q)));

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (chan_en == 8'h00 && ctrl_q == 8'h00 && !sda_oe));

  // R8
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R4
  en_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> $countones(chan_en) == $countones($past(ctrl_q)));
endmodule

bind i2csel_switch i2csel_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .ctrl_q   (ctrl_q),
  .stop_det (stop_det),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe)
);

// File: tb/i2csel_switch_bench.sv
module i2csel_switch_bench;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap = 3'd0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] chan_en;
  logic       sda_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_ctrl = 8'h00;
  logic [7:0] exp_en   = 8'h00;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2csel_switch u_i2csel_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strap (strap),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .chan_en    (chan_en)
  );

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b1110, s, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw();
    scl_m = 1'b1; qw(2);
    scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    b = sda_line; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic do_read(input string req);
    logic ack;
    logic [7:0] v;
    i2c_start();
    put_byte(addr_byte(strap, 1'b1), ack);
    chk(ack, "R1 read address ack", {7'd0, ack}, 8'h01);
    get_byte(v, 1'b0);
    chk(v == exp_ctrl, req, v, exp_ctrl);
    i2c_stop();
    exp_en = exp_ctrl;
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    logic [7:0] d;
    int n;
    void'($urandom(32'd2718));
    qw(4);
    @(negedge clk) rst_n = 1'b1;
    qw(2);
    chk(chan_en == 8'h00, "R6 reset value", chan_en, 8'h00);
    chk(sda_oe == 1'b0, "R6 bus released", {7'd0, sda_oe}, 8'h00);
    do_read("R3 read after reset");

    // single write, deferred apply
    strap = 3'd5;
    i2c_start();
    put_byte(addr_byte(strap, 1'b0), ack);
    chk(ack, "R1 write address ack", {7'd0, ack}, 8'h01);
    put_byte(8'h4C, ack);
    chk(ack, "R7 data ack", {7'd0, ack}, 8'h01);
    exp_ctrl = 8'h4C;
    chk(chan_en == exp_en, "R5 held before STOP", chan_en, exp_en);
    i2c_stop();
    exp_en = exp_ctrl;
    chk(chan_en == 8'h4C, "R4 channels 6,3,2 enabled", chan_en, 8'h4C);

    // read with ack then nack: value repeats MSB first
    i2c_start();
    put_byte(addr_byte(strap, 1'b1), ack);
    get_byte(v, 1'b1);
    chk(v == 8'h4C, "R8 first read byte", v, 8'h4C);
    get_byte(v, 1'b0);
    chk(v == 8'h4C, "R9 repeated after ack", v, 8'h4C);
    chk(sda_oe == 1'b0, "R9 released after nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop();

    // mismatched address: no ack, data ignored
    i2c_start();
    put_byte(addr_byte(strap ^ 3'd2, 1'b0), ack);
    chk(!ack, "R7 mismatch no ack", {7'd0, ack}, 8'h00);
    put_byte(8'hFF, ack);
    chk(!ack, "R7 ignored data no ack", {7'd0, ack}, 8'h00);
    i2c_stop();
    chk(chan_en == 8'h4C, "R1 mismatch leaves outputs", chan_en, 8'h4C);
    do_read("R1 mismatch leaves register");

    // repeated START between write and read
    i2c_start();
    put_byte(addr_byte(strap, 1'b0), ack);
    put_byte(8'hA1, ack);
    exp_ctrl = 8'hA1;
    i2c_start();
    qw(2);
    chk(chan_en == 8'h4C, "R10 repeated START does not apply", chan_en, 8'h4C);
    put_byte(addr_byte(strap, 1'b1), ack);
    chk(ack, "R10 address after repeated START", {7'd0, ack}, 8'h01);
    get_byte(v, 1'b0);
    chk(v == 8'hA1, "R10 read sees stored byte", v, 8'hA1);
    i2c_stop();
    exp_en = exp_ctrl;
    chk(chan_en == 8'hA1, "R5 applied at STOP", chan_en, 8'hA1);

    // reset with a pending selection
    i2c_start();
    put_byte(addr_byte(strap, 1'b0), ack);
    put_byte(8'h3E, ack);
    @(negedge clk) rst_n = 1'b0;
    qw();
    @(negedge clk) rst_n = 1'b1;
    qw();
    chk(chan_en == 8'h00, "R6 reset clears outputs", chan_en, 8'h00);
    i2c_stop();
    exp_ctrl = 8'h00;
    exp_en   = 8'h00;
    chk(chan_en == 8'h00, "R6 reset clears register", chan_en, 8'h00);

    // random bursts, random straps
    for (int it = 0; it < 14; it++) begin
      strap = 3'($urandom);
      n = 1 + int'($urandom % 3);
      i2c_start();
      put_byte(addr_byte(strap, 1'b0), ack);
      chk(ack, "R1 random strap ack", {7'd0, ack}, 8'h01);
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        put_byte(d, ack);
        chk(ack, "R7 burst byte ack", {7'd0, ack}, 8'h01);
        exp_ctrl = d;
      end
      chk(chan_en == exp_en, "R5 burst held before STOP", chan_en, exp_en);
      i2c_stop();
      exp_en = exp_ctrl;
      chk(chan_en == exp_en, "R2 last byte kept", chan_en, exp_en);
      if (it % 3 == 0) do_read("R3 random readback");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule